// File: doc/BRIEF.md
# Sensitivity Map Lookup Engine

The engine receives a streamed error-message word that locates an upset in configuration memory by frame number and bit offset. It walks a sensitivity map held in external memory through a read-master port. The port supports wait states and byte lanes. For each lookup it reports whether the upset lies in a critical region, and it gives that region's identifier.

The map is a table of 32-bit base pointers, one word per frame, which starts at byte address `MAP_BASE`. Each pointer gives the byte address of that frame's region array, which holds one region byte per bit offset. Region 0 means the bit is not critical. A one-entry cache holds the most recently accepted location, so a repeat report of the same upset costs no memory traffic unless the bypass input is high. A message that arrives while a lookup is running is dropped, and a saturating counter records the drop.

Top module: `smap_lookup`

## Requirements
- R1: A message is taken only in a cycle where `msg_valid` is high and the engine is idle. The bit offset is `msg_word[BIT_W-1:0]` and the frame is `msg_word[BIT_W +: FRAME_W]`. All higher bits of the word are ignored, and so is any data while `msg_valid` is low.
- R2: A message with `msg_err` high is discarded. It causes no read and no report, and it leaves the cache entry unchanged.
- R3: Each lookup first reads the pointer word at byte address `MAP_BASE + 4*frame` with `rd_lanes` = 4'b1111. The whole 32-bit word is used as the pointer.
- R4: The second read uses address (pointer + bit) with bits [1:0] cleared. `rd_lanes` is one-hot at bit position (pointer + bit)[1:0]. The region byte is taken from that lane, and the other lanes of `rd_data` are ignored.
- R5: While `rd_wait` is high at a rising edge with `rd_req` high, `rd_req` and `rd_addr` hold. `rd_req` falls after the first edge at which `rd_wait` is low.
- R6: `rd_data` is captured only in a cycle where `rd_dvalid` is high, while a read is outstanding.
- R7: Each completed lookup pulses exactly one of `hit_critical` or `hit_benign` for one cycle, in the cycle after the region byte is captured. At the same time `region_id` takes the low `REGION_W` bits of that byte and holds them until the next report. ID 0 pulses `hit_benign`; any other ID pulses `hit_critical`.
- R8: If a message's location (frame and bit) equals the last accepted location and `cmp_bypass` is low, no read and no report follow.
- R9: With `cmp_bypass` high, a message whose location matches the cached one still starts a full lookup.
- R10: A valid, error-free message that arrives while a lookup is running is dropped. It does not affect the running lookup, and it adds one to `drop_count`, which saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_word | input | EMR_W | Error-message word |
| msg_valid | input | 1 | Message strobe |
| msg_err | input | 1 | Upstream overrun marker; the message is discarded |
| cmp_bypass | input | 1 | Forces a lookup even on a cache match |
| rd_addr | output | ADDR_W | Byte address of the 32-bit word to read |
| rd_req | output | 1 | Read request |
| rd_lanes | output | 4 | Byte lanes needed |
| rd_wait | input | 1 | Memory stall |
| rd_data | input | 32 | Read data |
| rd_dvalid | input | 1 | Read data valid |
| hit_critical | output | 1 | Pulse: upset is in a critical region |
| hit_benign | output | 1 | Pulse: upset is in a noncritical region |
| region_id | output | REGION_W | Region of the last reported upset |
| drop_count | output | DROP_W | Saturating count of messages dropped while busy |

## Verification
The engine is swept over every frame and bit offset of a small configuration. Frame pointers are deliberately unaligned, so all four byte lanes and both critical and noncritical outcomes occur. Wait-state counts and response latencies rotate across the sweep, and unselected lanes and idle-cycle data are filled with junk, which separates correct lane and strobe handling from accidental matches. Directed patterns then separate the remaining cases: a repeated location, a repeat with bypass, an overrun-marked message that would otherwise evict the cache, a message without valid, and bursts of messages during a stalled lookup that push the drop counter to saturation.

// File: rtl/smap_lookup.sv
module smap_lookup #(
  parameter int EMR_W    = 67,
  parameter int FRAME_W  = 12,
  parameter int BIT_W    = 12,
  parameter int REGION_W = 8,
  parameter int DROP_W   = 8,
  parameter int ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MAP_BASE = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [EMR_W-1:0]    msg_word,
  input  logic                msg_valid,
  input  logic                msg_err,
  input  logic                cmp_bypass,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_req,
  output logic [3:0]          rd_lanes,
  input  logic                rd_wait,
  input  logic [31:0]         rd_data,
  input  logic                rd_dvalid,
  output logic                hit_critical,
  output logic                hit_benign,
  output logic [REGION_W-1:0] region_id,
  output logic [DROP_W-1:0]   drop_count
);
  localparam int LOC_W = FRAME_W + BIT_W;
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_TREQ, S_TRSP, S_RREQ, S_RRSP} state_t;

  state_t             state;
  logic [LOC_W-1:0]   cache_loc, cur_loc;
  logic               cache_ok;
  logic [ADDR_W-1:0]  byte_addr;

  logic [LOC_W-1:0]   loc;
  logic               take, hit, busy, unused_hi;
  logic [7:0]         lane_byte;
  logic [REGION_W-1:0] new_id;

  assign loc       = msg_word[LOC_W-1:0];
  assign unused_hi = ^msg_word[EMR_W-1:LOC_W];
  assign busy      = (state != S_IDLE);
  assign take      = msg_valid && !msg_err && !busy;
  assign hit       = cache_ok && (cache_loc == loc) && !cmp_bypass;
  assign lane_byte = rd_data[{byte_addr[1:0], 3'b000} +: 8];
  assign new_id    = lane_byte[REGION_W-1:0];

  assign rd_req   = (state == S_TREQ) || (state == S_RREQ);
  assign rd_addr  = (state == S_TREQ)
                  ? MAP_BASE + (ADDR_W'(cur_loc[LOC_W-1:BIT_W]) << 2)
                  : {byte_addr[ADDR_W-1:2], 2'b00};
  assign rd_lanes = (state == S_TREQ) ? 4'b1111 : (4'b0001 << byte_addr[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      cache_ok     <= 1'b0;
      cache_loc    <= '0;
      cur_loc      <= '0;
      byte_addr    <= '0;
      hit_critical <= 1'b0;
      hit_benign   <= 1'b0;
      region_id    <= '0;
      drop_count   <= '0;
    end else begin
      hit_critical <= 1'b0;
      hit_benign   <= 1'b0;
      if (msg_valid && !msg_err && busy && drop_count != DROP_MAX)
        drop_count <= drop_count + 1'b1;
      case (state)
        S_IDLE: if (take) begin
          cache_ok  <= 1'b1;
          cache_loc <= loc;
          if (!hit) begin
            cur_loc <= loc;
            state   <= S_TREQ;
          end
        end
        S_TREQ: if (!rd_wait) state <= S_TRSP;
        S_TRSP: if (rd_dvalid) begin
          byte_addr <= ADDR_W'(rd_data) + ADDR_W'(cur_loc[BIT_W-1:0]);
          state     <= S_RREQ;
        end
        S_RREQ: if (!rd_wait) state <= S_RRSP;
        S_RRSP: if (rd_dvalid) begin
          region_id    <= new_id;
          hit_critical <= |new_id;
          hit_benign   <= ~|new_id;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_one_flag_r7: assert property (@(posedge clk) disable iff (rst)
    !(hit_critical && hit_benign));
  p_flag_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (hit_critical || hit_benign) |=> !hit_critical && !hit_benign);
  p_id_class_r7: assert property (@(posedge clk) disable iff (rst)
    hit_benign |-> region_id == '0);
  p_hold_wait_r5: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_wait |=> rd_req && $stable(rd_addr) && $stable(rd_lanes));
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_wait |=> !rd_req);
  p_lanes_r4: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_lanes == 4'b1111 || $countones(rd_lanes) == 1);
  p_drop_mono_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drop_count >= $past(drop_count));
  p_err_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy && msg_valid && msg_err |=> !rd_req);
endmodule

// File: tb/smap_lookup_bench.sv
module smap_lookup_bench;
  localparam int FW = 3, BW = 5, DW = 2, EW = 67;

  logic clk = 1'b0, rst = 1'b1;
  logic [EW-1:0] msg_word = '0;
  logic msg_valid = 1'b0, msg_err = 1'b0, cmp_bypass = 1'b0;
  logic [31:0] rd_addr;
  logic rd_req;
  logic [3:0] rd_lanes;
  logic rd_wait = 1'b0, rd_dvalid = 1'b0;
  logic [31:0] rd_data = 32'hDEADBEEF;
  logic hit_critical, hit_benign;
  logic [7:0] region_id;
  logic [DW-1:0] drop_count;

  int checks = 0, errors = 0;
  int waits_cfg = 0, lat_cfg = 0;
  int cur_f = 0, cur_b = 0;

  always #2.5 clk = ~clk;

  smap_lookup #(.FRAME_W(FW), .BIT_W(BW), .DROP_W(DW)) u_smap_lookup (
    .clk(clk), .rst(rst), .msg_word(msg_word), .msg_valid(msg_valid),
    .msg_err(msg_err), .cmp_bypass(cmp_bypass), .rd_addr(rd_addr),
    .rd_req(rd_req), .rd_lanes(rd_lanes), .rd_wait(rd_wait),
    .rd_data(rd_data), .rd_dvalid(rd_dvalid), .hit_critical(hit_critical),
    .hit_benign(hit_benign), .region_id(region_id), .drop_count(drop_count));

  function automatic logic [31:0] ptr_of(int f);
    return 32'h100 + 32'(f * 37);
  endfunction

  function automatic logic [7:0] rb(logic [31:0] a);
    if (a % 5 == 0) return 8'h00;
    return 8'(((a * 29 + 7) % 255) + 1);
  endfunction

  function automatic logic [31:0] word_at(logic [31:0] w);
    if (w < 32'h100) return ptr_of(int'(w >> 2));
    return {rb(w + 3), rb(w + 2), rb(w + 1), rb(w)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, driven away from the active edge
  bit pend = 0, inreq = 0;
  int wc = 0, lc = 0;
  logic [31:0] acc_addr;
  logic [3:0] acc_be;
  always @(negedge clk) begin
    rd_dvalid = 1'b0;
    rd_data   = 32'hDEADBEEF;      // R6: junk while not valid
    if (rst) begin
      pend = 0; inreq = 0; rd_wait = 1'b0;
    end else if (rd_req && !pend) begin
      if (!inreq) begin inreq = 1; wc = waits_cfg; end
      if (wc > 0) begin
        rd_wait = 1'b1; wc--;
      end else begin
        logic [31:0] ea;
        rd_wait = 1'b0; pend = 1; inreq = 0; lc = lat_cfg;
        acc_addr = rd_addr; acc_be = rd_lanes;
        ea = ptr_of(cur_f) + 32'(cur_b);
        if (rd_addr < 32'h100) begin
          check(rd_addr == 32'(cur_f * 4), "R3 addr", rd_addr, 32'(cur_f * 4));
          check(rd_lanes == 4'hF, "R3 lanes", 32'(rd_lanes), 32'hF);
        end else begin
          check(rd_addr == {ea[31:2], 2'b00}, "R4 addr", rd_addr, {ea[31:2], 2'b00});
          check(rd_lanes == (4'b1 << ea[1:0]), "R4 lanes", 32'(rd_lanes),
                32'(4'b1 << ea[1:0]));
        end
      end
    end else if (pend) begin
      rd_wait = 1'b0;
      if (lc == 0) begin
        logic [31:0] d;
        d = word_at(acc_addr);
        for (int k = 0; k < 4; k++)
          if (!acc_be[k]) d[8*k +: 8] = d[8*k +: 8] ^ 8'h5A;   // R4: junk lanes
        rd_dvalid = 1'b1; rd_data = d; pend = 0;
      end else lc--;
    end else rd_wait = 1'b0;
  end

  task automatic send(int f, int b, bit err, bit byp, bit vld, logic [EW-1:0] hi);
    @(negedge clk);
    msg_word   = (hi << (FW + BW)) | EW'((f << BW) | b);
    msg_err    = err; cmp_bypass = byp; msg_valid = vld;
    @(negedge clk);
    msg_valid = 1'b0; msg_err = 1'b0; cmp_bypass = 1'b0;
  endtask

  task automatic expect_report(int f, int b, string req);
    logic [7:0] e;
    bit seen = 0;
    e = rb(ptr_of(f) + 32'(b));
    for (int i = 0; i < 200 && !seen; i++) begin
      if (hit_critical || hit_benign) seen = 1;
      else @(negedge clk);
    end
    check(seen, {req, " report"}, 32'(seen), 1);
    check(hit_critical == (e != 0) && hit_benign == (e == 0), {req, " R7 class"},
          {30'b0, hit_critical, hit_benign}, (e != 0) ? 32'h2 : 32'h1);
    check(region_id == e, {req, " R7 id"}, 32'(region_id), 32'(e));
    @(negedge clk);
    check(!hit_critical && !hit_benign && region_id == e, "R7 single pulse",
          {22'b0, region_id, hit_critical, hit_benign}, {22'b0, e, 2'b00});
  endtask

  task automatic expect_quiet(int n, string req);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rd_req || hit_critical || hit_benign) bad = 1;
    end
    check(!bad, req, 32'(bad), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!rd_req && !hit_critical && !hit_benign && region_id == 0 && drop_count == 0,
          "reset", {rd_req, hit_critical, hit_benign, region_id, drop_count}, 0);
    rst = 1'b0;
    // R1 R3 R4 R5 R6 R7: every location, rotating stalls and latencies
    for (int f = 0; f < (1 << FW); f++)
      for (int b = 0; b < (1 << BW); b++) begin
        int idx;
        idx = f * (1 << BW) + b;
        waits_cfg = idx % 3; lat_cfg = (idx / 3) % 3;
        cur_f = f; cur_b = b;
        send(f, b, 0, 0, 1, EW'(idx * 7919 + 3));
        expect_report(f, b, "R1 sweep");
      end
    // R8: repeat of last location, different upper bits
    send(cur_f, cur_b, 0, 0, 1, EW'(12345));
    expect_quiet(20, "R8 repeat suppressed");
    // R1: data present without valid
    send(2, 9, 0, 0, 0, '0);
    expect_quiet(20, "R1 no valid ignored");
    // R2: overrun-marked message, new location
    send(1, 4, 1, 0, 1, '0);
    expect_quiet(20, "R2 error discarded");
    send(cur_f, cur_b, 0, 0, 1, '0);
    expect_quiet(20, "R2 cache unchanged R8");
    // R9: bypass forces lookup of cached location
    waits_cfg = 2; lat_cfg = 1;
    send(cur_f, cur_b, 0, 1, 1, '0);
    expect_report(cur_f, cur_b, "R9 bypass");
    // R10: drop during a stalled lookup
    waits_cfg = 6; lat_cfg = 2; cur_f = 3; cur_b = 17;
    send(3, 17, 0, 0, 1, '0);
    send(5, 2, 0, 0, 1, '0);
    expect_report(3, 17, "R10 busy lookup intact");
    check(drop_count == 1, "R10 count", 32'(drop_count), 1);
    expect_quiet(20, "R10 dropped no lookup");
    waits_cfg = 10; cur_f = 6; cur_b = 30;
    send(6, 30, 0, 0, 1, '0);
    for (int k = 0; k < 4; k++) send(k, k, 0, 0, 1, '0);
    expect_report(6, 30, "R10 saturate lookup");
    check(drop_count == 3, "R10 saturation", 32'(drop_count), 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule